// File: doc/BRIEF.md
# Parallel Bus Initiator Phase Sequencer

This block lets a small 8-bit host run transfers on a parallel peripheral bus that has a single initiator and several targets. The host supplies a target number and a command block, then pulses a start request. The block selects the target straight from bus free, since there is no arbitration. It drives a select line together with a one-hot target bit on the data bus, and waits for the target to raise busy. If busy does not come within a parameterised number of cycles, the block gives up and reports that no target answered.

Once the target holds busy, the target decides what happens next. On each request strobe the block decodes the three phase lines the target presents. Depending on the phase, it drives a byte (command bytes, host data-out bytes, a no-operation message) or captures one (data-in bytes, the status byte, the message byte). Each byte is closed with a full four-phase request/acknowledge handshake.

The block keeps no phase order and no byte count to decide when a stream ends. A stream ends only when the target changes phase or drops busy. When busy is released, the block reports completion. The result counts as good only if a status byte and a final zero message byte were received.

Top module: `scsi_initiator_seq`

## Requirements
- R1: After reset, select, acknowledge, bus reset and data drive are all released; `active`, `done`, `err_no_target` and `err_sequence` are 0.
- R2: A start pulse with bus free asserts `bus_select_o` and drives `bus_data_o` with only bit N set, where N is `host_target_id`, with `bus_data_oe_o` high.
- R3: In the cycle after busy is sampled high during selection, select and data drive are released.
- R4: If busy stays low for `SEL_TIMEOUT` cycles of selection, the block releases the bus, sets `err_no_target` and pulses `done` once.
- R5: The phase {msg,cd,io} decodes as 000 data out, 001 data in, 010 command, 011 status, 110 message out, 111 message in, in any order the target chooses. A request in phase 100 or 101 is never acknowledged.
- R6: Each byte uses a four-phase handshake. Acknowledge rises only after request is seen, stays high until request falls, and driven data stays stable while acknowledge is high.
- R7: In the command phase, byte k of `host_cmd` (bits [8k+7:8k]) is sent in order from k=0. Requests beyond `CMD_BYTES` are answered with 00.
- R8: In the data-out phase, each byte is taken from `dout_data` and followed one cycle later by a `dout_take` pulse. While `dout_valid` is low, a pending request gets no acknowledge.
- R9: Every data-in byte appears, in arrival order, as a one-cycle `din_valid` pulse with `din_data`, for as many bytes as the target sends.
- R10: The status-phase byte is held on `status_byte` and the last message-in byte on `msg_byte`. A message-out request is answered with 08 (no operation).
- R11: When busy falls during a connection, `done` pulses for one cycle. `err_sequence` is 0 only if a status byte arrived and the last message-in byte was 00.
- R12: A start pulse is ignored while busy is high on the bus or while the block is active.
- R13: A `host_bus_reset` pulse makes `bus_reset_o` high in the next cycle, releases select and acknowledge, and returns to idle without a `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_start | input | 1 | Begin selection (pulse) |
| host_target_id | input | ID_W | Target number to select |
| host_cmd | input | CMD_BYTES*DATA_W | Command block, byte 0 in the low bits |
| host_bus_reset | input | 1 | Request a bus reset pulse |
| dout_valid | input | 1 | Host has a data-out byte ready |
| dout_data | input | DATA_W | Host data-out byte |
| dout_take | output | 1 | Data-out byte consumed |
| din_valid | output | 1 | Data-in byte strobe |
| din_data | output | DATA_W | Data-in byte |
| status_byte | output | DATA_W | Captured status byte |
| msg_byte | output | DATA_W | Last message-in byte |
| done | output | 1 | Transaction finished (pulse) |
| err_no_target | output | 1 | Selection timed out |
| err_sequence | output | 1 | Ended without status and a zero message |
| active | output | 1 | Block not idle |
| bus_busy_i | input | 1 | Bus busy line |
| bus_req_i | input | 1 | Target request strobe |
| bus_io_i | input | 1 | Phase line: direction |
| bus_cd_i | input | 1 | Phase line: control/data |
| bus_msg_i | input | 1 | Phase line: message |
| bus_data_i | input | DATA_W | Bus data as seen on the wire |
| bus_select_o | output | 1 | Select line drive |
| bus_ack_o | output | 1 | Acknowledge line drive |
| bus_reset_o | output | 1 | Bus reset line drive |
| bus_data_o | output | DATA_W | Bus data drive value |
| bus_data_oe_o | output | 1 | Bus data drive enable |

## Verification
A controller stuck in selection shows at once as select held past the busy edge. A lost timer shows as a missing `done` after `SEL_TIMEOUT` cycles. A handshake engine in the wrong state either never raises acknowledge, which makes the target model stall within a few cycles, or drops it early while request is high. A wrong command index or a missed phase decode gives a wrong byte at the very next acknowledge. Stale status or message registers show up only at the end of the transaction, through `err_sequence` and the captured bytes.

// File: rtl/sis_pkg.sv
package sis_pkg;
  typedef enum logic [2:0] {
    PH_DOUT = 3'b000,
    PH_DIN  = 3'b001,
    PH_CMD  = 3'b010,
    PH_STAT = 3'b011,
    PH_RSV4 = 3'b100,
    PH_RSV5 = 3'b101,
    PH_MOUT = 3'b110,
    PH_MIN  = 3'b111
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEL  = 2'd1,
    ST_CONN = 2'd2
  } ctl_e;

  typedef enum logic [1:0] {
    HS_WAIT  = 2'd0,
    HS_SETUP = 2'd1,
    HS_ACK   = 2'd2
  } hs_e;

  localparam logic [7:0] MSG_NOP  = 8'h08;
  localparam logic [7:0] MSG_DONE = 8'h00;
endpackage

// File: rtl/sis_phase_decode.sv
module sis_phase_decode
  import sis_pkg::*;
(
  input  logic   msg_i,
  input  logic   cd_i,
  input  logic   io_i,
  output phase_e phase_o,
  output logic   rsv_o
);
  always_comb begin
    phase_o = phase_e'({msg_i, cd_i, io_i});
    rsv_o   = (phase_o == PH_RSV4) || (phase_o == PH_RSV5);
  end
endmodule

// File: rtl/sis_sel_timer.sv
module sis_sel_timer #(
  parameter int SEL_TIMEOUT = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = $clog2(SEL_TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SEL_TIMEOUT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    if (!run_i)              cnt_d = '0;
    else if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
    else begin
      cnt_d  = cnt_q;
      cnt_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == LIMIT);

  // a stopped timer never reports expiry in the following cycle
  assert_timer_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !expired_o);
endmodule

// File: rtl/sis_byte_handshake.sv
module sis_byte_handshake
  import sis_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort_i,
  input  logic              req_i,
  input  phase_e            phase_i,
  input  logic              rsv_i,
  input  logic [DATA_W-1:0] out_byte_i,
  input  logic              out_ok_i,
  output logic              ack_o,
  output logic              oe_o,
  output logic [DATA_W-1:0] data_o,
  output logic              take_o,
  output logic              in_valid_o,
  output logic              idle_o
);
  hs_e               st_q, st_d;
  logic [DATA_W-1:0] data_q;
  logic              out_q;
  logic              dir_in;
  logic              start_ok;

  always_comb begin
    dir_in     = phase_i[0];
    start_ok   = (st_q == HS_WAIT) && !abort_i && req_i && !rsv_i;
    take_o     = start_ok && !dir_in && out_ok_i;
    in_valid_o = start_ok && dir_in;
  end

  always_comb begin
    st_d = st_q;
    if (abort_i) st_d = HS_WAIT;
    else begin
      case (st_q)
        HS_WAIT: begin
          if (take_o)          st_d = HS_SETUP;
          else if (in_valid_o) st_d = HS_ACK;
        end
        HS_SETUP: st_d = HS_ACK;
        HS_ACK:   if (!req_i) st_d = HS_WAIT;
        default:  st_d = HS_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= HS_WAIT;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      out_q  <= 1'b0;
    end else begin
      if (take_o)               data_q <= out_byte_i;
      if (take_o || in_valid_o) out_q  <= take_o;
    end
  end

  assign ack_o  = (st_q == HS_ACK);
  assign oe_o   = (st_q == HS_SETUP) || ((st_q == HS_ACK) && out_q);
  assign data_o = data_q;
  assign idle_o = (st_q == HS_WAIT);

  // acknowledge is held for as long as request stays high
  assert_ack_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && req_i && !abort_i) |=> ack_o);
endmodule

// File: rtl/scsi_initiator_seq.sv
module scsi_initiator_seq
  import sis_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ID_W        = 3,
  parameter int CMD_BYTES   = 6,
  parameter int SEL_TIMEOUT = 200
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        host_start,
  input  logic [ID_W-1:0]             host_target_id,
  input  logic [CMD_BYTES*DATA_W-1:0] host_cmd,
  input  logic                        host_bus_reset,
  input  logic                        dout_valid,
  input  logic [DATA_W-1:0]           dout_data,
  output logic                        dout_take,
  output logic                        din_valid,
  output logic [DATA_W-1:0]           din_data,
  output logic [DATA_W-1:0]           status_byte,
  output logic [DATA_W-1:0]           msg_byte,
  output logic                        done,
  output logic                        err_no_target,
  output logic                        err_sequence,
  output logic                        active,
  input  logic                        bus_busy_i,
  input  logic                        bus_req_i,
  input  logic                        bus_io_i,
  input  logic                        bus_cd_i,
  input  logic                        bus_msg_i,
  input  logic [DATA_W-1:0]           bus_data_i,
  output logic                        bus_select_o,
  output logic                        bus_ack_o,
  output logic                        bus_reset_o,
  output logic [DATA_W-1:0]           bus_data_o,
  output logic                        bus_data_oe_o
);
  localparam int CIW = $clog2(CMD_BYTES + 1);
  localparam logic [CIW-1:0] CMD_LAST = CIW'(CMD_BYTES);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  // phase decode
  phase_e phase;
  logic   phase_rsv;
  sis_phase_decode u_dec (
    .msg_i   (bus_msg_i),
    .cd_i    (bus_cd_i),
    .io_i    (bus_io_i),
    .phase_o (phase),
    .rsv_o   (phase_rsv)
  );

  // control state
  ctl_e st_q, st_d;
  logic go_sel, fin_ok, fin_nt;
  logic tmo;
  logic hs_idle, hs_ack, hs_oe, hs_take, hs_inv;
  logic [DATA_W-1:0] hs_data;
  logic abort;

  sis_sel_timer #(.SEL_TIMEOUT(SEL_TIMEOUT)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .run_i     (st_q == ST_SEL),
    .expired_o (tmo)
  );

  always_comb begin
    st_d   = st_q;
    go_sel = 1'b0;
    fin_ok = 1'b0;
    fin_nt = 1'b0;
    case (st_q)
      ST_IDLE: if (host_start && !bus_busy_i) begin
        st_d   = ST_SEL;
        go_sel = 1'b1;
      end
      ST_SEL: begin
        if (bus_busy_i) st_d = ST_CONN;
        else if (tmo) begin
          st_d   = ST_IDLE;
          fin_nt = 1'b1;
        end
      end
      ST_CONN: if (!bus_busy_i && hs_idle) begin
        st_d   = ST_IDLE;
        fin_ok = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
    if (host_bus_reset) begin
      st_d   = ST_IDLE;
      go_sel = 1'b0;
      fin_ok = 1'b0;
      fin_nt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) st_q <= ST_IDLE;
    else             st_q <= st_d;
  end

  // byte source for outbound phases
  logic [DATA_W-1:0] cmd_q [CMD_BYTES];
  logic [CIW-1:0]    cmd_idx_q;
  logic [DATA_W-1:0] out_byte;
  logic              out_ok;

  always_comb begin
    out_byte = '0;
    out_ok   = 1'b1;
    case (phase)
      PH_CMD:  if (cmd_idx_q < CMD_LAST) out_byte = cmd_q[cmd_idx_q];
      PH_DOUT: begin
        out_byte = dout_data;
        out_ok   = dout_valid;
      end
      PH_MOUT: out_byte = DATA_W'(MSG_NOP);
      default: out_byte = '0;
    endcase
  end

  assign abort = (st_q != ST_CONN) || !bus_busy_i || host_bus_reset;

  sis_byte_handshake #(.DATA_W(DATA_W)) u_hs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .abort_i    (abort),
    .req_i      (bus_req_i),
    .phase_i    (phase),
    .rsv_i      (phase_rsv),
    .out_byte_i (out_byte),
    .out_ok_i   (out_ok),
    .ack_o      (hs_ack),
    .oe_o       (hs_oe),
    .data_o     (hs_data),
    .take_o     (hs_take),
    .in_valid_o (hs_inv),
    .idle_o     (hs_idle)
  );

  // datapath registers with explicit enables
  logic [ID_W-1:0]   id_q;
  logic [DATA_W-1:0] status_q, msg_q, din_q;
  logic              got_status_q, got_msg_q;
  logic              done_q, err_nt_q, err_seq_q, din_v_q, take_q, rst_out_q;
  logic              cap_stat, cap_msg, cap_din, cmd_step;

  always_comb begin
    cap_stat = hs_inv && (phase == PH_STAT);
    cap_msg  = hs_inv && (phase == PH_MIN);
    cap_din  = hs_inv && (phase == PH_DIN);
    cmd_step = hs_take && (phase == PH_CMD) && (cmd_idx_q < CMD_LAST);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      id_q         <= '0;
      cmd_idx_q    <= '0;
      status_q     <= '0;
      msg_q        <= '0;
      din_q        <= '0;
      got_status_q <= 1'b0;
      got_msg_q    <= 1'b0;
      done_q       <= 1'b0;
      err_nt_q     <= 1'b0;
      err_seq_q    <= 1'b0;
      din_v_q      <= 1'b0;
      take_q       <= 1'b0;
      rst_out_q    <= 1'b0;
      for (int k = 0; k < CMD_BYTES; k++) cmd_q[k] <= '0;
    end else begin
      done_q    <= fin_ok || fin_nt;
      din_v_q   <= cap_din;
      take_q    <= hs_take && (phase == PH_DOUT);
      rst_out_q <= host_bus_reset;
      if (go_sel) begin
        id_q         <= host_target_id;
        cmd_idx_q    <= '0;
        status_q     <= '0;
        msg_q        <= '0;
        got_status_q <= 1'b0;
        got_msg_q    <= 1'b0;
        err_nt_q     <= 1'b0;
        err_seq_q    <= 1'b0;
        for (int k = 0; k < CMD_BYTES; k++)
          cmd_q[k] <= host_cmd[k*DATA_W +: DATA_W];
      end
      if (cmd_step) cmd_idx_q <= cmd_idx_q + 1'b1;
      if (cap_din)  din_q <= bus_data_i;
      if (cap_stat) begin
        status_q     <= bus_data_i;
        got_status_q <= 1'b1;
      end
      if (cap_msg) begin
        msg_q     <= bus_data_i;
        got_msg_q <= 1'b1;
      end
      if (fin_nt) err_nt_q <= 1'b1;
      if (fin_ok)
        err_seq_q <= !(got_status_q && got_msg_q && (msg_q == DATA_W'(MSG_DONE)));
    end
  end

  // outputs
  logic [DATA_W-1:0] sel_pattern;
  assign sel_pattern   = DATA_W'(1) << id_q;
  assign bus_select_o  = (st_q == ST_SEL);
  assign bus_ack_o     = hs_ack;
  assign bus_reset_o   = rst_out_q;
  assign bus_data_oe_o = (st_q == ST_SEL) || hs_oe;
  assign bus_data_o    = (st_q == ST_SEL) ? sel_pattern : (hs_oe ? hs_data : '0);
  assign dout_take     = take_q;
  assign din_valid     = din_v_q;
  assign din_data      = din_q;
  assign status_byte   = status_q;
  assign msg_byte      = msg_q;
  assign done          = done_q;
  assign err_no_target = err_nt_q;
  assign err_sequence  = err_seq_q;
  assign active        = (st_q != ST_IDLE);

  // checks next to the logic they guard
  assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_select_o |-> (bus_data_oe_o && ($countones(bus_data_o) == 1)));

  assert_sel_release_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_select_o && bus_busy_i && !host_bus_reset) |=> (!bus_select_o && !bus_data_oe_o));

  assert_rsv_no_ack_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_req_i && phase_rsv && !bus_ack_o) |=> !bus_ack_o);

  assert_data_stable_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_ack_o && bus_data_oe_o) |-> $stable(bus_data_o));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done);

  assert_err_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(err_no_target && err_sequence));

  assert_bus_reset_R13: assert property (@(posedge clk) disable iff (!rst_sync_n)
    host_bus_reset |=> (bus_reset_o && !bus_select_o && !bus_ack_o && !active));
endmodule

// File: tb/tb_scsi_initiator_seq.sv
`timescale 1ns/1ps
module tb_scsi_initiator_seq;
  localparam int DW   = 8;
  localparam int IW   = 3;
  localparam int NCMD = 6;
  localparam int TMO  = 200;
  localparam logic [2:0] P_DOUT = 3'b000, P_DIN = 3'b001, P_CMD = 3'b010,
                         P_STAT = 3'b011, P_RSV = 3'b100, P_MOUT = 3'b110,
                         P_MIN = 3'b111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic               host_start = 1'b0;
  logic [IW-1:0]      host_target_id = '0;
  logic [NCMD*DW-1:0] host_cmd = '0;
  logic               host_bus_reset = 1'b0;
  logic               dout_valid = 1'b0;
  logic [DW-1:0]      dout_data = '0;
  logic               dout_take, din_valid, done, err_no_target, err_sequence, active;
  logic [DW-1:0]      din_data, status_byte, msg_byte;
  logic t_busy = 1'b0, t_req = 1'b0, t_io = 1'b0, t_cd = 1'b0, t_msg = 1'b0;
  logic [DW-1:0]      t_data = '0;
  logic               bus_select_o, bus_ack_o, bus_reset_o, bus_data_oe_o;
  logic [DW-1:0]      bus_data_o;

  scsi_initiator_seq #(.DATA_W(DW), .ID_W(IW), .CMD_BYTES(NCMD), .SEL_TIMEOUT(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .host_start(host_start), .host_target_id(host_target_id),
    .host_cmd(host_cmd), .host_bus_reset(host_bus_reset), .dout_valid(dout_valid),
    .dout_data(dout_data), .dout_take(dout_take), .din_valid(din_valid), .din_data(din_data),
    .status_byte(status_byte), .msg_byte(msg_byte), .done(done),
    .err_no_target(err_no_target), .err_sequence(err_sequence), .active(active),
    .bus_busy_i(t_busy), .bus_req_i(t_req), .bus_io_i(t_io), .bus_cd_i(t_cd),
    .bus_msg_i(t_msg), .bus_data_i(t_data), .bus_select_o(bus_select_o),
    .bus_ack_o(bus_ack_o), .bus_reset_o(bus_reset_o), .bus_data_o(bus_data_o),
    .bus_data_oe_o(bus_data_oe_o)
  );

  int n_cmp = 0, n_bad = 0;
  int done_cnt = 0, din_n = 0, dout_idx = 0;
  logic [DW-1:0] din_got [64];
  logic [DW-1:0] dout_src [64];
  logic [DW-1:0] din_exp [64];
  logic [DW-1:0] cmd_b [NCMD];

  function automatic logic [DW-1:0] exp_sel(int id);
    return DW'(1) << id;
  endfunction

  function automatic logic exp_seq_err(logic saw_status, logic [DW-1:0] last_msg);
    return !(saw_status && last_msg == 8'h00);
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // host-side monitors, sampled away from the active edge
  always @(negedge clk) begin
    if (din_valid) begin
      if (din_n < 64) din_got[din_n] = din_data;
      din_n++;
    end
    if (done) done_cnt++;
    if (dout_take) begin
      dout_idx++;
      dout_data = dout_src[dout_idx % 64];
    end
  end

  task automatic wait_ack(logic lvl, string tag);
    int g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (bus_ack_o !== lvl && g < 300);
    if (bus_ack_o !== lvl) check(tag, "ack wait", bus_ack_o, lvl);
  endtask

  task automatic tgt_in(logic [2:0] ph, logic [DW-1:0] b, string tag);
    {t_msg, t_cd, t_io} = ph;
    t_data = b;
    t_req = 1'b1;
    wait_ack(1'b1, tag);
    t_req = 1'b0;
    wait_ack(1'b0, tag);
  endtask

  task automatic tgt_out(logic [2:0] ph, output logic [DW-1:0] b, input string tag);
    {t_msg, t_cd, t_io} = ph;
    t_req = 1'b1;
    wait_ack(1'b1, tag);
    b = bus_data_oe_o ? bus_data_o : 8'hzz;
    t_req = 1'b0;
    wait_ack(1'b0, tag);
  endtask

  task automatic do_start(int id);
    logic [NCMD*DW-1:0] v;
    for (int k = 0; k < NCMD; k++) v[k*DW +: DW] = cmd_b[k];
    host_target_id = IW'(id);
    host_cmd = v;
    host_start = 1'b1;
    @(negedge clk);
    host_start = 1'b0;
  endtask

  task automatic answer_select(int id);
    check("R2", "select asserted", bus_select_o, 1);
    check("R2", "select pattern", {bus_data_oe_o, bus_data_o}, {1'b1, exp_sel(id)});
    t_busy = 1'b1;
    @(negedge clk);
    check("R3", "select/drive released", {bus_select_o, bus_data_oe_o}, 2'b00);
  endtask

  task automatic send_cmd(int nreq);
    logic [DW-1:0] b;
    for (int k = 0; k < nreq; k++) begin
      tgt_out(P_CMD, b, "R7");
      check("R7", $sformatf("command byte %0d", k), b, (k < NCMD) ? cmd_b[k] : 8'h00);
    end
  endtask

  task automatic finish_conn(logic saw_status, logic [DW-1:0] st, logic [DW-1:0] last_msg);
    t_busy = 1'b0;
    {t_msg, t_cd, t_io} = 3'b000;
    @(negedge clk);
    check("R11", "done pulse", done, 1);
    check("R11", "sequence flag", err_sequence, exp_seq_err(saw_status, last_msg));
    check("R10", "message byte", msg_byte, last_msg);
    if (saw_status) check("R10", "status byte", status_byte, st);
    @(negedge clk);
    check("R11", "done one cycle", done, 0);
  endtask

  task automatic run_read(int id, int n);
    logic [DW-1:0] b, st;
    for (int k = 0; k < NCMD; k++) cmd_b[k] = DW'($urandom);
    cmd_b[0] = 8'h08;
    din_n = 0;
    do_start(id);
    answer_select(id);
    if ($urandom % 2) begin
      tgt_out(P_MOUT, b, "R10");
      check("R10", "message out", b, 8'h08);
    end
    send_cmd(NCMD);
    for (int k = 0; k < n; k++) begin
      din_exp[k] = DW'($urandom);
      tgt_in(P_DIN, din_exp[k], "R9");
    end
    st = DW'($urandom);
    tgt_in(P_STAT, st, "R5");
    tgt_in(P_MIN, 8'h00, "R5");
    check("R9", "data-in count", din_n, n);
    for (int k = 0; k < n; k++) check("R9", $sformatf("data-in byte %0d", k), din_got[k], din_exp[k]);
    finish_conn(1'b1, st, 8'h00);
  endtask

  task automatic run_write(int id, int n, bit gap);
    logic [DW-1:0] b, st;
    for (int k = 0; k < NCMD; k++) cmd_b[k] = DW'($urandom);
    cmd_b[0] = 8'h0A;
    for (int k = 0; k < n; k++) dout_src[k] = DW'($urandom);
    dout_idx = 0;
    dout_data = dout_src[0];
    dout_valid = 1'b1;
    do_start(id);
    answer_select(id);
    send_cmd(NCMD);
    for (int k = 0; k < n; k++) begin
      if (gap && k == 1) begin
        dout_valid = 1'b0;
        {t_msg, t_cd, t_io} = P_DOUT;
        t_req = 1'b1;
        repeat (6) @(negedge clk);
        check("R8", "no ack without host byte", bus_ack_o, 0);
        dout_valid = 1'b1;
        wait_ack(1'b1, "R8");
        b = bus_data_o;
        t_req = 1'b0;
        wait_ack(1'b0, "R8");
      end else begin
        tgt_out(P_DOUT, b, "R8");
      end
      check("R8", $sformatf("data-out byte %0d", k), b, dout_src[k]);
      if (k == n / 2 && ($urandom % 2)) begin
        tgt_out(P_MOUT, b, "R10");
        check("R10", "message out", b, 8'h08);
      end
    end
    check("R8", "take pulses", dout_idx, n);
    dout_valid = 1'b0;
    st = DW'($urandom);
    tgt_in(P_STAT, st, "R5");
    tgt_in(P_MIN, 8'h00, "R5");
    finish_conn(1'b1, st, 8'h00);
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (R1-level run): actual hung expected finished");
    report();
    $finish;
  end

  initial begin
    int dc;
    logic [DW-1:0] st;
    void'($urandom(32'h5C51));
    repeat (3) @(negedge clk);
    check("R1", "outputs in reset", {bus_select_o, bus_ack_o, bus_reset_o, bus_data_oe_o}, 4'b0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "outputs after reset", {bus_select_o, bus_ack_o, bus_reset_o, bus_data_oe_o}, 4'b0000);
    check("R1", "flags after reset", {active, done, err_no_target, err_sequence}, 4'b0000);

    // R12: start with the bus held busy
    t_busy = 1'b1;
    do_start(2);
    @(negedge clk);
    check("R12", "start ignored when bus busy", {bus_select_o, active}, 2'b00);
    t_busy = 1'b0;
    @(negedge clk);

    // R4: nobody answers
    dc = done_cnt;
    do_start(5);
    repeat (TMO / 2) @(negedge clk);
    check("R4", "still selecting", {bus_select_o, err_no_target}, 2'b10);
    repeat (TMO / 2 + 10) @(negedge clk);
    check("R4", "timeout flag", err_no_target, 1);
    check("R4", "bus released", {bus_select_o, bus_data_oe_o, active}, 3'b000);
    check("R4", "single done", done_cnt - dc, 1);

    // random mix of read and write transactions
    for (int t = 0; t < 10; t++) begin
      if (t % 2 == 0) run_read(int'($urandom % 8), 1 + int'($urandom % 12));
      else            run_write(int'($urandom % 8), 2 + int'($urandom % 10), t == 3);
    end

    // directed: overlong command, reserved phase, ignored start, bad message
    for (int k = 0; k < NCMD; k++) cmd_b[k] = DW'(8'h30 + k);
    do_start(7);
    answer_select(7);
    host_target_id = 3'd1;
    host_start = 1'b1;
    @(negedge clk);
    host_start = 1'b0;
    @(negedge clk);
    check("R12", "start ignored while active", {bus_select_o, active}, 2'b01);
    send_cmd(NCMD + 1);
    {t_msg, t_cd, t_io} = P_RSV;
    t_req = 1'b1;
    repeat (6) @(negedge clk);
    check("R5", "reserved phase not acknowledged", bus_ack_o, 0);
    t_req = 1'b0;
    @(negedge clk);
    st = 8'h02;
    tgt_in(P_STAT, st, "R5");
    tgt_in(P_MIN, 8'h04, "R5");
    finish_conn(1'b1, st, 8'h04);

    // directed: zero message but no status byte
    do_start(0);
    answer_select(0);
    send_cmd(NCMD);
    tgt_in(P_MIN, 8'h00, "R11");
    finish_conn(1'b0, 8'h00, 8'h00);

    // R13: bus reset in the middle of a handshake
    do_start(3);
    answer_select(3);
    {t_msg, t_cd, t_io} = P_DIN;
    t_data = 8'hA5;
    t_req = 1'b1;
    wait_ack(1'b1, "R13");
    dc = done_cnt;
    host_bus_reset = 1'b1;
    @(negedge clk);
    host_bus_reset = 1'b0;
    check("R13", "reset line pulsed", bus_reset_o, 1);
    check("R13", "bus released", {bus_ack_o, bus_select_o, active}, 3'b000);
    t_req = 1'b0;
    t_busy = 1'b0;
    repeat (3) @(negedge clk);
    check("R13", "reset line dropped", bus_reset_o, 0);
    check("R13", "no done after reset", done_cnt - dc, 0);

    report();
    $finish;
  end
endmodule